// File: doc/BRIEF.md
# Trigger-Aligned Serial ADC Lane Demultiplexer

This block takes a single serial data lane from a multi-channel ADC, the level of that lane's frame clock, and a trigger pulse. All three arrive as one sample per bit time in the fabric clock domain. The block cuts the bit stream into words at frame-clock transitions. It assembles each word most-significant bit first and tags it with the channel it belongs to. It then presents the word with a single-cycle valid strobe.

The lane runs in one of two modes. In normal mode it carries two channels per conversion, and the frame-clock level alone names the channel. In quad mode it carries four channels per conversion, and the frame clock runs high, low, high, low. The two high phases cannot be told apart by level, so the block anchors its slot sequence to a trigger. The trigger is registered first. A programmable latency, counted in half-conversion units, then runs out, and the next rising frame edge marks the first channel. From that point the slots are labelled in the order the lane carries them.

A sticky flag reports a frame-clock transition that lands inside a word instead of on a word boundary.

Top module: `lane_demux`

## Requirements
- R1: While reset is held and just after it is released, `wordValid`, `alignErr`, `wordOut` and `chanIdx` are all zero.
- R2: Each word is the N bits of one frame phase, and the first bit of the phase becomes bit N-1 (MSB-first). `wordValid` pulses for exactly one cycle, in the clock edge that samples the phase's last bit.
- R3: In normal mode (`quadMode`=0), words start with the first frame-clock transition after reset, and every phase then yields a word. A word from a high phase carries `chanIdx`=0 and a word from a low phase carries `chanIdx`=1.
- R4: In quad mode (`quadMode`=1), once anchored, successive phases carry `chanIdx` 0, 2, 1, 3, and the order repeats. The anchor phase is index 0.
- R5: In quad mode, no word is made valid before the first anchor that follows a trigger.
- R6: Suppose a `trigIn` pulse is presented in bit time c and `latencyHalf`=L. The anchor is then the first rising frame-clock transition at or after bit time c+3+L·2N. Here 2N bit times is half of a quad-mode conversion.
- R7: A later trigger re-anchors the slot sequence. Words before the new anchor keep the old sequence, and the new anchor phase restarts at `chanIdx`=0.
- R8: In normal mode `trigIn` has no effect on word contents, channel labels or validity.
- R9: After the first frame transition, a transition arriving before N bits of the current phase have been received sets `alignErr`. It stays set until reset, and clean streams never set it.
- R10: `latencyHalf`=17, a latency of 8.5 conversions, anchors as R6 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate fabric clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quadMode | input | 1 | 0: two channels per conversion; 1: four channels per conversion |
| latencyHalf | input | LAT_W | Trigger-to-anchor latency in half-conversion units |
| serBit | input | 1 | Serial data bit for this bit time |
| frameLvl | input | 1 | Frame-clock level for this bit time |
| trigIn | input | 1 | Trigger pulse |
| wordOut | output | N | Assembled word |
| chanIdx | output | 2 | Channel index of `wordOut` |
| wordValid | output | 1 | One-cycle strobe marking a new word |
| alignErr | output | 1 | Sticky misplaced-transition flag |

## Verification
The bench places triggers so that the latency runs out partway through a frame phase. A design that counts one cycle too few or too many therefore anchors on a different high phase, and the whole label sequence shifts. A trigger placed just ahead of a low phase tests that anchoring waits for a rising transition. A second trigger with a different latency tests that words keep their old labels until the new anchor arrives. A design that relabels at once, or that goes invalid while re-arming, is caught there. Normal-mode runs with a stray trigger catch a block that lets the anchor logic leak into polarity labelling. A shortened phase checks both that the error flag is raised and that it is held.

// File: rtl/lane_demux_pkg.sv
package lane_demux_pkg;

  // Strobes handed from the control path to the datapath.
  typedef struct packed {
    logic       emit;   // latch the word completed in this bit time
    logic [1:0] chan;   // channel label for that word
  } demuxCtrl_t;

  // Quad-mode slot position to channel index: the lane carries the
  // first, third, second and fourth channel of its group in turn.
  function automatic logic [1:0] slotToChan(input logic [1:0] slot);
    logic [1:0] c;
    case (slot)
      2'd0:    c = 2'd0;
      2'd1:    c = 2'd2;
      2'd2:    c = 2'd1;
      default: c = 2'd3;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lane_demux_ctrl.sv
module lane_demux_ctrl
  import lane_demux_pkg::*;
#(
  parameter int N     = 12,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             quadMode,
  input  logic [LAT_W-1:0] latencyHalf,
  input  logic             frameLvl,
  input  logic             trigIn,
  output demuxCtrl_t       ctrlOut,
  output logic             alignErr
);
  localparam int CNT_W     = $clog2(N + 1);
  localparam int HALF_BITS = 2 * N;
  localparam int LAT_MAX   = ((1 << LAT_W) - 1) * HALF_BITS;
  localparam int LATC_W    = $clog2(LAT_MAX + 1);

  // frame tracking
  logic             frameQ;
  logic             synced;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitCntNext;
  logic             frameEdge;
  logic             sampleStart;
  logic             sampleDone;
  logic             misEdge;
  logic             errQ;

  // trigger / latency / anchor
  logic              trigQ;
  logic              trigPrev;
  logic              trigRise;
  logic              counting;
  logic [LATC_W-1:0] latCnt;
  logic [LATC_W-1:0] latTarget;
  logic              armed;
  logic              anchorNow;
  logic              anchored;
  logic [1:0]        curSlot;

  assign frameEdge   = frameLvl ^ frameQ;
  assign sampleStart = frameEdge || (synced && (bitCnt == CNT_W'(N)));
  assign bitCntNext  = sampleStart ? CNT_W'(1) : bitCnt + 1'b1;
  assign sampleDone  = (synced || frameEdge) && (bitCntNext == CNT_W'(N));
  assign misEdge     = synced && frameEdge && (bitCnt != CNT_W'(N));

  assign trigRise  = trigQ & ~trigPrev;
  assign latTarget = LATC_W'(latencyHalf) * LATC_W'(HALF_BITS);
  assign anchorNow = quadMode && armed && frameEdge && frameLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= 1'b0;
      synced <= 1'b0;
      bitCnt <= '0;
      errQ   <= 1'b0;
    end else begin
      frameQ <= frameLvl;
      if (synced || frameEdge) begin
        bitCnt <= bitCntNext;
        synced <= 1'b1;
      end
      if (misEdge) errQ <= 1'b1;
    end
  end

  // Trigger is registered into the sampling domain before any use.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ    <= 1'b0;
      trigPrev <= 1'b0;
    end else begin
      trigQ    <= trigIn;
      trigPrev <= trigQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counting <= 1'b0;
      latCnt   <= '0;
      armed    <= 1'b0;
    end else if (!quadMode) begin
      counting <= 1'b0;
      latCnt   <= '0;
      armed    <= 1'b0;
    end else if (trigRise) begin
      counting <= 1'b1;
      latCnt   <= '0;
      armed    <= 1'b0;
    end else if (counting) begin
      if (latCnt == latTarget) begin
        counting <= 1'b0;
        armed    <= 1'b1;
      end else begin
        latCnt <= latCnt + 1'b1;
      end
    end else if (anchorNow) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anchored <= 1'b0;
      curSlot  <= 2'd0;
    end else begin
      if (!quadMode)      anchored <= 1'b0;
      else if (anchorNow) anchored <= 1'b1;

      if (anchorNow)                   curSlot <= 2'd0;
      else if (synced && sampleStart)  curSlot <= curSlot + 2'd1;
    end
  end

  always_comb begin
    ctrlOut.emit = sampleDone && (!quadMode || anchored);
    if (quadMode) ctrlOut.chan = slotToChan(curSlot);
    else          ctrlOut.chan = frameLvl ? 2'd0 : 2'd1;
  end

  assign alignErr = errQ;

endmodule

// File: rtl/lane_demux_dp.sv
module lane_demux_dp
  import lane_demux_pkg::*;
#(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serBit,
  input  demuxCtrl_t   ctrlIn,
  output logic [N-1:0] wordOut,
  output logic [1:0]   chanIdx,
  output logic         wordValid
);
  logic [N-1:0] shReg;
  logic [N-1:0] shNext;

  // MSB-first: earlier bits migrate toward the top as new bits enter.
  assign shNext = {shReg[N-2:0], serBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      wordOut   <= '0;
      chanIdx   <= 2'd0;
      wordValid <= 1'b0;
    end else begin
      shReg     <= shNext;
      wordValid <= ctrlIn.emit;
      if (ctrlIn.emit) begin
        wordOut <= shNext;
        chanIdx <= ctrlIn.chan;
      end
    end
  end

endmodule

// File: rtl/lane_demux.sv
module lane_demux
  import lane_demux_pkg::*;
#(
  parameter int N     = 12,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             quadMode,
  input  logic [LAT_W-1:0] latencyHalf,
  input  logic             serBit,
  input  logic             frameLvl,
  input  logic             trigIn,
  output logic [N-1:0]     wordOut,
  output logic [1:0]       chanIdx,
  output logic             wordValid,
  output logic             alignErr
);
  demuxCtrl_t ctrlBus;

  lane_demux_ctrl #(.N(N), .LAT_W(LAT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .quadMode    (quadMode),
    .latencyHalf (latencyHalf),
    .frameLvl    (frameLvl),
    .trigIn      (trigIn),
    .ctrlOut     (ctrlBus),
    .alignErr    (alignErr)
  );

  lane_demux_dp #(.N(N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .serBit    (serBit),
    .ctrlIn    (ctrlBus),
    .wordOut   (wordOut),
    .chanIdx   (chanIdx),
    .wordValid (wordValid)
  );

endmodule

// File: rtl/lane_demux_chk.sv
module lane_demux_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rstN,
  input logic         quadMode,
  input logic         trigIn,
  input logic [N-1:0] wordOut,
  input logic [1:0]   chanIdx,
  input logic         wordValid,
  input logic         alignErr
);
  logic       seenTrig;
  logic       quadQ;
  logic       haveLast;
  logic [1:0] lastChan;
  logic [1:0] expNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenTrig <= 1'b0;
      quadQ    <= 1'b0;
      haveLast <= 1'b0;
      lastChan <= 2'd0;
    end else begin
      quadQ <= quadMode;
      if (trigIn) seenTrig <= 1'b1;
      if (!quadMode || !quadQ) haveLast <= 1'b0;
      else if (wordValid) begin
        haveLast <= 1'b1;
        lastChan <= chanIdx;
      end
    end
  end

  always_comb begin
    case (lastChan)
      2'd0:    expNext = 2'd2;
      2'd2:    expNext = 2'd1;
      2'd1:    expNext = 2'd3;
      default: expNext = 2'd0;
    endcase
  end

  // R2: the valid strobe lasts one cycle
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R3: normal mode labels only channels 0 and 1
  a_r3_normal_chan: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !quadQ) |-> (chanIdx[1] == 1'b0));

  // R4: quad order 0,2,1,3 unless restarting at 0
  a_r4_quad_order: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && quadQ && quadMode && haveLast && chanIdx != 2'd0)
      |-> (chanIdx == expNext));

  // R5: nothing valid in quad mode before any trigger
  a_r5_silent_untriggered: assert property (@(posedge clk) disable iff (!rstN)
    (quadMode && quadQ && !seenTrig) |-> !wordValid);

  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> alignErr);

endmodule

bind lane_demux lane_demux_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .quadMode  (quadMode),
  .trigIn    (trigIn),
  .wordOut   (wordOut),
  .chanIdx   (chanIdx),
  .wordValid (wordValid),
  .alignErr  (alignErr)
);

// File: tb/sim_lane_demux.sv
`timescale 1ns/1ps
module sim_lane_demux;
  localparam int N     = 12;
  localparam int LAT_W = 6;
  localparam int MAXP  = 64;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             quadMode = 1'b0;
  logic [LAT_W-1:0] latencyHalf = '0;
  logic             serBit = 1'b0;
  logic             frameLvl = 1'b0;
  logic             trigIn = 1'b0;
  logic [N-1:0]     wordOut;
  logic [1:0]       chanIdx;
  logic             wordValid;
  logic             alignErr;

  int checks = 0;
  int failures = 0;

  int           gotCnt  [MAXP];
  logic [N-1:0] gotWord [MAXP];
  logic [1:0]   gotChan [MAXP];
  logic         errSeen [MAXP];

  always #2.5 clk = ~clk;

  lane_demux #(.N(N), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rstN(rstN), .quadMode(quadMode), .latencyHalf(latencyHalf),
    .serBit(serBit), .frameLvl(frameLvl), .trigIn(trigIn),
    .wordOut(wordOut), .chanIdx(chanIdx), .wordValid(wordValid), .alignErr(alignErr)
  );

  function automatic logic [N-1:0] phaseData(input int p);
    return N'(p * 173 + 41);
  endfunction

  function automatic int anchorPh(input int c, input int l);
    int m, p;
    m = c + 3 + l * 2 * N;
    p = (m + N - 1) / N;
    if (p % 2 != 0) p++;
    return p;
  endfunction

  function automatic logic [1:0] slotChan(input int s);
    case (s % 4)
      0: return 2'd0;
      1: return 2'd2;
      2: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; quadMode = 1'b0; latencyHalf = '0;
    serBit = 1'b0; frameLvl = 1'b0; trigIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sampleOut(input int ph);
    if (wordValid && ph >= 0) begin
      gotCnt[ph]++;
      gotWord[ph] = wordOut;
      gotChan[ph] = chanIdx;
    end
  endtask

  task automatic runStream(input int nPh, input bit quad, input int trigA,
                           input int latA, input int trigB, input int latB,
                           input int shortPh);
    int b;
    int lastPh;
    logic [N-1:0] d;
    for (int p = 0; p < MAXP; p++) begin
      gotCnt[p] = 0; gotWord[p] = '0; gotChan[p] = 2'd0; errSeen[p] = 1'b0;
    end
    quadMode = quad;
    latencyHalf = LAT_W'(latA);
    b = 0;
    lastPh = -1;
    for (int p = 0; p < nPh; p++) begin
      int len;
      len = (p == shortPh) ? N - 3 : N;
      d = phaseData(p);
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        sampleOut(lastPh);
        if (i == 0) errSeen[p] = alignErr;
        frameLvl = (p % 2 == 0);
        serBit = d[N-1-i];
        trigIn = (b == trigA) || (b == trigB);
        if (b == trigB) latencyHalf = LAT_W'(latB);
        b++;
        lastPh = p;
      end
    end
    @(negedge clk);
    sampleOut(lastPh);
    trigIn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    chk(wordValid == 1'b0, "R1", "wordValid after reset", int'(wordValid), 0);
    chk(alignErr == 1'b0, "R1", "alignErr after reset", int'(alignErr), 0);
    chk(wordOut == '0, "R1", "wordOut after reset", int'(wordOut), 0);
    chk(chanIdx == 2'd0, "R1", "chanIdx after reset", int'(chanIdx), 0);
  endtask

  // Normal mode, with a stray trigger at bit 37 (phase 3) that must be ignored.
  task automatic testNormal();
    doReset();
    runStream(10, 1'b0, 37, 5, -1, 0, -1);
    for (int p = 0; p < 10; p++) begin
      string rq;
      rq = (p >= 3) ? "R8" : "R3";
      chk(gotCnt[p] == 1, rq, $sformatf("normal phase %0d word count", p), gotCnt[p], 1);
      chk(gotWord[p] == phaseData(p), "R2", $sformatf("normal phase %0d word", p),
          int'(gotWord[p]), int'(phaseData(p)));
      chk(gotChan[p] == ((p % 2 == 0) ? 2'd0 : 2'd1), rq,
          $sformatf("normal phase %0d chan", p), int'(gotChan[p]), p % 2);
    end
    chk(alignErr == 1'b0, "R9", "clean normal stream err", int'(alignErr), 0);
  endtask

  task automatic testQuadNoTrig();
    int tot;
    doReset();
    runStream(16, 1'b1, -1, 0, -1, 0, -1);
    tot = 0;
    for (int p = 0; p < 16; p++) tot += gotCnt[p];
    chk(tot == 0, "R5", "quad words without trigger", tot, 0);
  endtask

  // Trigger at a conversion start with 8.5 conversions of latency.
  task automatic testQuadAnchor();
    int a;
    doReset();
    a = anchorPh(96, 17);
    runStream(52, 1'b1, 96, 17, -1, 0, -1);
    for (int p = 0; p < 52; p++) begin
      if (p < a) begin
        chk(gotCnt[p] == 0, "R5", $sformatf("pre-anchor phase %0d", p), gotCnt[p], 0);
      end else begin
        chk(gotCnt[p] == 1, "R10", $sformatf("anchored phase %0d count", p), gotCnt[p], 1);
        chk(gotChan[p] == slotChan(p - a), "R4", $sformatf("anchored phase %0d chan", p),
            int'(gotChan[p]), int'(slotChan(p - a)));
        chk(gotWord[p] == phaseData(p), "R2", $sformatf("anchored phase %0d word", p),
            int'(gotWord[p]), int'(phaseData(p)));
      end
    end
    chk(alignErr == 1'b0, "R9", "clean quad stream err", int'(alignErr), 0);
  endtask

  // First anchor lands on the second high phase, a second trigger realigns.
  task automatic testReanchor();
    int a1, a2;
    doReset();
    a1 = anchorPh(62, 0);
    a2 = anchorPh(240, 1);
    runStream(32, 1'b1, 62, 0, 240, 1, -1);
    for (int p = 0; p < 32; p++) begin
      if (p < a1) begin
        chk(gotCnt[p] == 0, "R6", $sformatf("reanchor pre phase %0d", p), gotCnt[p], 0);
      end else if (p < a2) begin
        chk(gotCnt[p] == 1, "R6", $sformatf("first anchor phase %0d count", p), gotCnt[p], 1);
        chk(gotChan[p] == slotChan(p - a1), "R6", $sformatf("first anchor phase %0d chan", p),
            int'(gotChan[p]), int'(slotChan(p - a1)));
      end else begin
        chk(gotCnt[p] == 1, "R7", $sformatf("second anchor phase %0d count", p), gotCnt[p], 1);
        chk(gotChan[p] == slotChan(p - a2), "R7", $sformatf("second anchor phase %0d chan", p),
            int'(gotChan[p]), int'(slotChan(p - a2)));
      end
    end
  endtask

  task automatic testError();
    doReset();
    runStream(10, 1'b0, -1, 0, -1, 0, 6);
    chk(errSeen[6] == 1'b0, "R9", "err before short phase", int'(errSeen[6]), 0);
    chk(errSeen[7] == 1'b0, "R9", "err during short phase", int'(errSeen[7]), 0);
    chk(errSeen[8] == 1'b1, "R9", "err after misplaced edge", int'(errSeen[8]), 1);
    repeat (30) @(negedge clk);
    chk(alignErr == 1'b1, "R9", "err sticky", int'(alignErr), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testNormal();
    testQuadNoTrig();
    testQuadAnchor();
    testReanchor();
    testError();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule